// File: doc/BRIEF.md
# 100 Mbit/s Receive Start-of-Stream Detector

This block sits behind the descrambler of a 100 Mbit/s receiver and takes one code bit per clock. It keeps the last ten code bits (two 5B code groups) in a sliding window. From that window it decides whether a frame is starting, whether the line shows a corrupt delimiter, or whether the activity is noise to be ignored. Once a valid /J/K/ delimiter is found, the delimiter position fixes the 5B symbol boundaries. Every later code group is then decoded into a 4-bit nibble for the controller side. The delimiter itself is handed on as two data-5 nibbles.

A corrupt delimiter is reported as false carrier. Carrier sense and the receive error flag are raised, data-valid stays low, a fixed error nibble is driven, and a sticky status bit is set. The detector then refuses any new delimiter until a full idle pair has passed through the window. Software-side logic clears the sticky bit with a one-cycle pulse.

Top module: `rx_sos_detect`

## Requirements
- R1: The window holds the last ten received bits with the earliest at the most significant position. Code groups are idle I = 11111, J = 11000, K = 10001, so the delimiter window reads 1100010001.
- R2: While `rst_n` is low at a clock edge, all outputs go low (`rxd` = 0, `start_err` = 0). While idle, `crs`, `rx_dv` and `rx_er` stay low and `rxd` = 0.
- R3: In idle, a decision is taken only in a cycle whose three oldest window bits are 1,1,0. If the window is then /J/K/, `crs` and `rx_dv` rise at the next edge with `rxd` = 4'h5. One symbol period later `rxd` is 4'h5 again, standing for K.
- R4: After the delimiter, `rxd` changes only on symbol boundaries, every 5 clocks. It carries the decode of the code group one symbol behind the newest, using the 4B5B data table: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R5: A group that is not in the data table, received during a frame, gives `rx_er` = 1 and `rxd` = 4'h0 with `rx_dv` still high, for that nibble period only.
- R6: A frame ends when the window on a symbol boundary holds /I/I/. At the next edge `crs`, `rx_dv` and `rx_er` fall and `rxd` = 0.
- R7: A decision window that is not /J/K/ but holds two zero runs separated by ones is false carrier. From the next edge `crs` = 1, `rx_er` = 1, `rx_dv` = 0 and `rxd` = 4'hE.
- R8: `start_err` is set at the same edge that false carrier begins. A one-cycle `err_clr` clears it unless false carrier begins in that cycle. Otherwise it holds.
- R9: After false carrier, outputs stay in the false-carrier pattern and delimiters are not accepted until the window holds ten ones at any alignment. Normal idle behaviour resumes at the following edge.
- R10: A decision window with all its zeros in one contiguous run is ignored. The block stays idle and `start_err` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one code bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| code_bit | input | 1 | Descrambled serial code bit |
| err_clr | input | 1 | One-cycle clear of the sticky start error |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rxd | output | 4 | Receive nibble |
| start_err | output | 1 | Sticky bad-delimiter status |

## Verification
A code bit presented before edge N enters the window at N. Any decision that uses it shows on the outputs after edge N+1. A data nibble appears five clocks after its own code group completes, because output runs one symbol behind the newest group. The bench drives inputs and compares outputs on the falling edge. A cycle model advances once per driven bit, so every comparison is made against what the previous rising edge must have produced. Directed probes sample mid-symbol, where values are settled.

// File: rtl/rxsos_pkg.sv
// Package: shared constants and state type of the start-of-stream detector.
// Assumes 5B code groups and 4-bit receive nibbles.
package rxsos_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;
    localparam int WIN_W = 2 * SYM_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_FCAR = 2'd2
    } rx_state_e;

    localparam logic [SYM_W-1:0] CG_IDLE  = 5'b11111;
    localparam logic [SYM_W-1:0] CG_FIRST = 5'b11000;
    localparam logic [SYM_W-1:0] CG_SECND = 5'b10001;
    localparam logic [NIB_W-1:0] NIB_SUBST = 4'h5;
    localparam logic [NIB_W-1:0] NIB_FCAR  = 4'hE;
endpackage

// File: rtl/rxsos_window.sv
// Module: sliding window of the most recent code bits.
// Assumes one valid bit per clock. The earliest bit sits at the MSB.
// Reset loads all ones so the window looks like line idle.
module rxsos_window #(
    parameter int WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win
);
    logic primed;

    // Shift the newest bit in at the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) win <= '1;
        else        win <= {win[WIN_W-2:0], bit_in};
    end

    // Mark that the previous edge was a normal shift edge.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (win[0] == $past(bit_in)));
    p_shift_age_r1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (win[WIN_W-1:1] == $past(win[WIN_W-2:0])));
endmodule

// File: rtl/rxsos_classify.sv
// Module: pattern flags for the current window.
// Assumes the window layout of rxsos_window. Purely combinational.
module rxsos_classify
    import rxsos_pkg::*;
#(
    parameter int WIN_W = 10
) (
    input  logic [WIN_W-1:0] win,
    output logic             idle_pair,
    output logic             sof_pair,
    output logic             anchor,
    output logic             split_zeros
);
    logic [WIN_W-1:0] run_head;

    // One flag per zero that begins a new run of zeros.
    for (genvar i = 0; i < WIN_W; i++) begin : g_run
        if (i == WIN_W - 1) begin : g_top
            assign run_head[i] = ~win[i];
        end else begin : g_rest
            assign run_head[i] = ~win[i] & win[i+1];
        end
    end

    // Compare against the idle and delimiter pairs and find the decision point.
    always_comb begin
        idle_pair   = (win == {CG_IDLE, CG_IDLE});
        sof_pair    = (win == {CG_FIRST, CG_SECND});
        anchor      = (win[WIN_W-1 -: 3] == 3'b110);
        split_zeros = ($countones(run_head) >= 2);
    end
endmodule

// File: rtl/rxsos_decode.sv
// Module: 5B to 4-bit data decoder.
// Groups outside the sixteen data codes report valid low and nibble zero.
module rxsos_decode
    import rxsos_pkg::*;
(
    input  logic [SYM_W-1:0] code,
    output logic [NIB_W-1:0] nib,
    output logic             valid
);
    // Table lookup of the data code groups.
    always_comb begin
        valid = 1'b1;
        unique case (code)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            default: begin
                nib   = 4'h0;
                valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rx_sos_detect.sv
// Module: 100 Mbit/s receive start-of-stream detector (top).
// Takes one descrambled code bit per clock and finds the /J/K/ delimiter.
// It fixes symbol alignment there and decodes nibbles one symbol behind.
// Bad delimiters are flagged as false carrier, which waits for idle.
// Assumes a synchronous active-low reset and registered outputs.
module rx_sos_detect
    import rxsos_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_bit,
    input  logic             err_clr,
    output logic             crs,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [NIB_W-1:0] rxd,
    output logic             start_err
);
    localparam int PH_W = $clog2(SYM_W + 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(SYM_W);
    localparam logic [PH_W-1:0] PH_FIRST = PH_W'(1);

    logic [WIN_W-1:0] win;
    logic             idle_pair, sof_pair, anchor, split_zeros;
    logic [NIB_W-1:0] dec_nib;
    logic             dec_ok;
    rx_state_e        st;
    logic [PH_W-1:0]  ph;
    logic             k_pending;
    logic             fc_enter;

    rxsos_window #(.WIN_W(WIN_W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (code_bit),
        .win    (win)
    );

    rxsos_classify #(.WIN_W(WIN_W)) u_classify (
        .win         (win),
        .idle_pair   (idle_pair),
        .sof_pair    (sof_pair),
        .anchor      (anchor),
        .split_zeros (split_zeros)
    );

    rxsos_decode u_decode (
        .code  (win[WIN_W-1 -: SYM_W]),
        .nib   (dec_nib),
        .valid (dec_ok)
    );

    // Detect the edge at which false carrier starts.
    always_comb begin
        fc_enter = (st == ST_IDLE) && anchor && !sof_pair && split_zeros;
    end

    // Receive state machine with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= '0;
            k_pending <= 1'b0;
            crs       <= 1'b0;
            rx_dv     <= 1'b0;
            rx_er     <= 1'b0;
            rxd       <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (anchor && sof_pair) begin
                        st        <= ST_RECV;
                        ph        <= PH_FIRST;
                        k_pending <= 1'b1;
                        crs       <= 1'b1;
                        rx_dv     <= 1'b1;
                        rx_er     <= 1'b0;
                        rxd       <= NIB_SUBST;
                    end else if (fc_enter) begin
                        st    <= ST_FCAR;
                        crs   <= 1'b1;
                        rx_dv <= 1'b0;
                        rx_er <= 1'b1;
                        rxd   <= NIB_FCAR;
                    end
                end
                ST_RECV: begin
                    if (ph == PH_LAST) begin
                        ph <= PH_FIRST;
                        if (idle_pair) begin
                            st    <= ST_IDLE;
                            crs   <= 1'b0;
                            rx_dv <= 1'b0;
                            rx_er <= 1'b0;
                            rxd   <= '0;
                        end else if (k_pending) begin
                            k_pending <= 1'b0;
                            rx_er     <= 1'b0;
                            rxd       <= NIB_SUBST;
                        end else begin
                            rx_er <= !dec_ok;
                            rxd   <= dec_nib;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_FCAR: begin
                    if (idle_pair) begin
                        st    <= ST_IDLE;
                        crs   <= 1'b0;
                        rx_er <= 1'b0;
                        rxd   <= '0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Sticky bad-delimiter flag; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_err <= 1'b0;
        else if (fc_enter) start_err <= 1'b1;
        else if (err_clr)  start_err <= 1'b0;
    end

    p_dv_needs_crs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> crs);
    p_quiet_no_carrier_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !crs |-> (!rx_dv && !rx_er && rxd == '0));
    p_fc_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (crs && !rx_dv) |-> (rx_er && rxd == NIB_FCAR));
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_err && !err_clr) |=> start_err);
    p_sticky_on_fc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (crs && !rx_dv && !$past(crs)) |-> start_err);
    p_nibble_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECV && $past(st) == ST_RECV && ph != PH_FIRST) |-> $stable(rxd));
    p_fc_until_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCAR && !idle_pair) |=> (st == ST_FCAR));
endmodule

// File: tb/rx_sos_detect_tb.sv
// Bench: directed corner cases plus seeded random traffic, compared each
// cycle against a bench-side cycle model of the requirements.
module rx_sos_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_bit = 1'b1;
    logic       err_clr = 1'b0;
    logic       crs, rx_dv, rx_er, start_err;
    logic [3:0] rxd;

    int total = 0;
    int bad = 0;

    // model state
    int         m_st = 0;
    logic [9:0] m_win = '1;
    int         m_ph = 0;
    logic       m_k = 1'b0;
    logic       e_crs = 0, e_dv = 0, e_er = 0, e_err = 0;
    logic [3:0] e_rxd = 0;

    localparam logic [4:0] SYM_I = 5'b11111;
    localparam logic [4:0] SYM_J = 5'b11000;
    localparam logic [4:0] SYM_K = 5'b10001;

    always #10 clk = ~clk;

    rx_sos_detect u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_bit  (code_bit),
        .err_clr   (err_clr),
        .crs       (crs),
        .rx_dv     (rx_dv),
        .rx_er     (rx_er),
        .rxd       (rxd),
        .start_err (start_err)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string t;
        t = (m_st == 0) ? "R2" : ((m_st == 1) ? "R4" : "R7");
        chk(t, "crs", 32'(crs), 32'(e_crs));
        chk(t, "rx_dv", 32'(rx_dv), 32'(e_dv));
        chk(t, "rx_er", 32'(rx_er), 32'(e_er));
        chk(t, "rxd", 32'(rxd), 32'(e_rxd));
        chk("R8", "start_err", 32'(start_err), 32'(e_err));
    endtask

    task automatic model_step(input logic b, input logic clr);
        logic anch, jk, ii, fc, v;
        logic [3:0] n;
        int runs;
        anch = (m_win[9:7] == 3'b110);
        jk   = (m_win == {SYM_J, SYM_K});
        ii   = (m_win == 10'h3ff);
        runs = 0;
        for (int i = 9; i >= 0; i--)
            if (!m_win[i] && ((i == 9) ? 1'b1 : m_win[i+1])) runs++;
        fc = 1'b0;
        case (m_st)
            0: if (anch) begin
                if (jk) begin
                    m_st = 1; m_ph = 1; m_k = 1;
                    e_crs = 1; e_dv = 1; e_er = 0; e_rxd = 4'h5;
                end else if (runs >= 2) begin
                    m_st = 2; fc = 1;
                    e_crs = 1; e_dv = 0; e_er = 1; e_rxd = 4'he;
                end
            end
            1: if (m_ph == 5) begin
                m_ph = 1;
                if (ii) begin
                    m_st = 0; e_crs = 0; e_dv = 0; e_er = 0; e_rxd = 0;
                end else if (m_k) begin
                    m_k = 0; e_rxd = 4'h5; e_er = 0;
                end else begin
                    v = 0; n = 0;
                    for (int c = 0; c < 16; c++)
                        if (enc(4'(c)) == m_win[9:5]) begin v = 1; n = 4'(c); end
                    e_rxd = n; e_er = !v;
                end
            end else m_ph++;
            default: if (ii) begin
                m_st = 0; e_crs = 0; e_dv = 0; e_er = 0; e_rxd = 0;
            end
        endcase
        e_err = fc ? 1'b1 : (clr ? 1'b0 : e_err);
        m_win = {m_win[8:0], b};
    endtask

    task automatic step(input logic b, input logic clr = 1'b0);
        @(negedge clk);
        compare_all();
        code_bit = b;
        err_clr  = clr;
        model_step(b, clr);
    endtask

    task automatic send_sym(input logic [4:0] s);
        for (int i = 4; i >= 0; i--) step(s[i]);
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    // watchdog
    initial begin
        #(20 * 180000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4051));
        repeat (3) @(negedge clk);
        chk("R2", "reset crs", 32'(crs), 0);
        chk("R2", "reset rxd", 32'(rxd), 0);
        chk("R2", "reset start_err", 32'(start_err), 0);
        rst_n = 1'b1;
        model_step(1'b1, 1'b0);
        ones(20);
        chk("R2", "idle crs", 32'(crs), 0);

        // R1/R3/R4/R5/R6: frame with an invalid group
        ones(7);
        send_sym(SYM_J); send_sym(SYM_K);
        step(enc(4'h3)[4]); step(enc(4'h3)[3]); step(enc(4'h3)[2]);
        chk("R1", "sof dv", 32'(rx_dv), 1);
        chk("R3", "J subst", 32'(rxd), 5);
        step(enc(4'h3)[1]); step(enc(4'h3)[0]);
        send_sym(5'b00000);
        step(enc(4'h9)[4]); step(enc(4'h9)[3]); step(enc(4'h9)[2]);
        chk("R4", "first data nibble", 32'(rxd), 3);
        step(enc(4'h9)[1]); step(enc(4'h9)[0]);
        step(enc(4'hC)[4]); step(enc(4'hC)[3]); step(enc(4'hC)[2]);
        chk("R5", "bad group er", 32'(rx_er), 1);
        chk("R5", "bad group rxd", 32'(rxd), 0);
        chk("R5", "bad group dv", 32'(rx_dv), 1);
        step(enc(4'hC)[1]); step(enc(4'hC)[0]);
        send_sym(SYM_I);
        chk("R5", "error one nibble", 32'(rx_er), 0);
        send_sym(SYM_I);
        ones(3);
        chk("R6", "end crs", 32'(crs), 0);
        chk("R6", "end dv", 32'(rx_dv), 0);

        // R10: single zero run ignored
        ones(5);
        step(0); step(0); step(0);
        ones(12);
        chk("R10", "single run crs", 32'(crs), 0);
        chk("R10", "single run err", 32'(start_err), 0);

        // R7/R8: split zeros -> false carrier
        step(0); step(1); step(0);
        ones(8);
        chk("R7", "fc crs", 32'(crs), 1);
        chk("R7", "fc er", 32'(rx_er), 1);
        chk("R7", "fc dv", 32'(rx_dv), 0);
        chk("R7", "fc rxd", 32'(rxd), 32'he);
        chk("R8", "sticky set", 32'(start_err), 1);
        ones(10);
        chk("R9", "idle after fc", 32'(crs), 0);
        chk("R8", "sticky hold", 32'(start_err), 1);
        step(1, 1); step(1);
        chk("R8", "sticky clear", 32'(start_err), 0);

        // R9: delimiter during false carrier not accepted
        ones(4);
        step(0); step(1); step(0);
        send_sym(SYM_J); send_sym(SYM_K);
        ones(3);
        chk("R9", "no sof in fc dv", 32'(rx_dv), 0);
        chk("R9", "still fc", 32'(crs), 1);
        ones(12);
        chk("R9", "rearmed idle", 32'(crs), 0);
        send_sym(SYM_J); send_sym(SYM_K);
        ones(3);
        chk("R9", "sof after rearm", 32'(rx_dv), 1);
        ones(12);
        chk("R6", "short frame end", 32'(crs), 0);

        // random traffic
        for (int it = 0; it < 300; it++) begin
            if ($urandom % 3 != 0) begin
                ones(2 + int'($urandom % 19));
                send_sym(SYM_J); send_sym(SYM_K);
                for (int d = 0, nd = 1 + int'($urandom % 20); d < nd; d++) begin
                    logic [4:0] s;
                    s = ($urandom % 16 == 0) ? 5'($urandom) : enc(4'($urandom));
                    for (int i = 4; i >= 0; i--) step(s[i], ($urandom % 8) == 0);
                end
                send_sym(SYM_I); send_sym(SYM_I);
                ones(5);
            end else begin
                for (int i = 0, nb = 1 + int'($urandom % 30); i < nb; i++)
                    step(1'($urandom), ($urandom % 8) == 0);
                ones(25);
            end
        end
        step(1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule